// File: doc/BRIEF.md
# Sequential NAND Block Write Manager

This block writes a stream of pages into one NAND erase block at a time. It sits between a page source and an operation-level flash port, which carries whole program and status-read operations. It holds the target block and the next page that may be written. A page request whose index does not follow the ascending order is refused. Every page is issued with a program confirm chosen from its position. All pages below the top page of the block use the cache-program confirm, so the source can refill the cache register while the array is still busy. The top page uses the normal program confirm, because cache programming may not cross a block boundary.

After each program the manager polls the device status. It keeps polling until the ready bit that belongs to the confirm in use is set, and then reads the pass/fail bit. A failure stalls the page source, reports the failing block number, and waits for a replacement block, where writing restarts at page 0. A passing top page reports the block as complete, and the manager then also waits for the next target block. The page most recently accepted may be programmed again as a partial program, within a fixed limit on the number of programs per page.

Top module: `nand_seq_writer`

## Requirements
- R1: During and straight after reset no target block is held: `wr_ready`, `fl_req`, `wr_refused`, `bad_valid` and `done_valid` are all 0.
- R2: `tgt_valid` loads `tgt_block` and resets the expected page to 0 only while the manager waits for a block. In any other state it has no effect, and later programs still address the old block.
- R3: While `wr_ready` is 1, a request with `wr_page` equal to the expected page is accepted. The expected page then becomes `wr_page`+1, and `wr_ready` falls in the next cycle.
- R4: While `wr_ready` is 1, a request that is neither the expected page nor an allowed partial program is refused. `wr_refused` pulses for one cycle in the next cycle, no flash operation is issued, and the expected page does not change.
- R5: The most recently accepted page may be requested again as a partial program while its total number of programs is below NOP_MAX (4). The request after that limit is refused.
- R6: A program is presented on `fl_op` with code 1 (cache confirm) for pages 0 to PAGES-2 and code 2 (normal confirm) for page PAGES-1. `fl_row` is {block, page} with the page in the low 6 bits. `fl_op` is 0 when no request is made.
- R7: After a program is granted, a status read (`fl_op` code 3, same row) is requested. The read is repeated after each response whose ready bit is 0. The ready bit is status bit 6 for a cache-confirmed page and status bit 5 for the top page.
- R8: A ready status with bit 0 set pulses `bad_valid` with `bad_block` equal to the current block, and the manager returns to waiting for a block.
- R9: A ready status with bit 0 clear for the top page pulses `done_valid` with `done_block` equal to the current block, and the manager then waits for a new block.
- R10: A ready, passing status for any lower page sets `wr_ready` again in the next cycle.
- R11: While `fl_req` is 1 and `fl_gnt` is 0, `fl_req`, `fl_op` and `fl_row` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | New target block offered |
| tgt_block | input | 11 | Target block number |
| wr_valid | input | 1 | Page write requested by the source |
| wr_page | input | 6 | Page index of the requested write |
| wr_ready | output | 1 | Manager can take a page request |
| wr_refused | output | 1 | One-cycle pulse: last request refused |
| fl_req | output | 1 | Flash operation requested |
| fl_op | output | 2 | 0 none, 1 cache program, 2 normal program, 3 status read |
| fl_row | output | 17 | Row address {block, page} |
| fl_gnt | input | 1 | Flash port accepts the requested operation |
| fl_rsp_valid | input | 1 | Status byte returned |
| fl_status | input | 8 | Status byte: bit 0 fail, bit 5 array ready, bit 6 cache ready |
| bad_valid | output | 1 | One-cycle pulse: program failed |
| bad_block | output | 11 | Block that failed |
| done_valid | output | 1 | One-cycle pulse: block fully written |
| done_block | output | 11 | Block that completed |

## Verification
Two events can meet in one cycle. A new target block may arrive in the same cycle as the status response that ends a block, whether by failure or by completion. The bench holds `tgt_valid` high through a failing program's status polling. In that case the offer must be ignored until the bad-block pulse has put the manager back into its waiting state, and only then taken. A page request may also be presented in the cycle its predecessor's status passes. The behavioural model in the bench judges every such cycle by comparing all outputs on each clock, including the block field of the row on the next program.

// File: rtl/nand_seq_writer_pkg.sv
package nand_seq_writer_pkg;

    // Operation codes presented on the flash operation port
    typedef enum logic [1:0] {
        OP_NONE       = 2'd0,
        OP_PROG_CACHE = 2'd1,
        OP_PROG_LAST  = 2'd2,
        OP_STATUS     = 2'd3
    } flash_op_e;

    typedef enum logic [2:0] {
        ST_NEED_BLK,
        ST_ACCEPT,
        ST_PROG,
        ST_POLL,
        ST_WAIT
    } wr_state_e;

    // Status byte bit positions
    localparam int STAT_FAIL_BIT  = 0;
    localparam int STAT_ARRAY_BIT = 5;
    localparam int STAT_CACHE_BIT = 6;

    typedef struct packed {
        logic ready;
        logic fail;
    } stat_eval_t;

    // Confirm code for a page given whether it is the top page
    function automatic flash_op_e confirm_for(input logic top_page);
        return top_page ? OP_PROG_LAST : OP_PROG_CACHE;
    endfunction

endpackage

// File: rtl/nsw_page_tracker.sv
module nsw_page_tracker #(
    parameter  int PAGES   = 64,
    parameter  int NOP_MAX = 4,
    localparam int PAGE_W  = $clog2(PAGES),
    localparam int CNT_W   = $clog2(NOP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              try_valid,
    input  logic [PAGE_W-1:0] try_page,
    output logic              accept,
    output logic              try_last
);

    localparam logic [PAGE_W-1:0] TOP_PAGE = PAGE_W'(PAGES - 1);

    logic [PAGE_W-1:0] nxt_q;
    logic [CNT_W-1:0]  nop_q;
    logic [PAGE_W-1:0] prev_pg;
    logic [PAGE_W-1:0] after_pg;
    logic              ok_new;
    logic              ok_part;

    always_comb begin
        prev_pg  = (nxt_q == '0) ? TOP_PAGE : nxt_q - 1'b1;
        after_pg = (try_page == TOP_PAGE) ? '0 : try_page + 1'b1;
        ok_new   = (try_page == nxt_q);
        ok_part  = (nop_q != '0) && (nop_q < CNT_W'(NOP_MAX)) && (try_page == prev_pg);
        accept   = try_valid && (ok_new || ok_part);
        try_last = (try_page == TOP_PAGE);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            nxt_q <= '0;
            nop_q <= '0;
        end else if (accept) begin
            if (ok_new) begin
                nxt_q <= after_pg;
                nop_q <= CNT_W'(1);
            end else begin
                nop_q <= nop_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nsw_status_eval.sv
module nsw_status_eval
    import nand_seq_writer_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] status,
    input  logic              top_page,
    output stat_eval_t        result
);

    always_comb begin
        result.ready = top_page ? status[STAT_ARRAY_BIT] : status[STAT_CACHE_BIT];
        result.fail  = status[STAT_FAIL_BIT];
    end

endmodule

// File: rtl/nand_seq_writer.sv
module nand_seq_writer
    import nand_seq_writer_pkg::*;
#(
    parameter  int PAGES   = 64,
    parameter  int BLOCKS  = 2048,
    parameter  int NOP_MAX = 4,
    parameter  int STAT_W  = 8,
    localparam int PAGE_W  = $clog2(PAGES),
    localparam int BLK_W   = $clog2(BLOCKS),
    localparam int ROW_W   = BLK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_valid,
    input  logic [BLK_W-1:0]  tgt_block,
    input  logic              wr_valid,
    input  logic [PAGE_W-1:0] wr_page,
    output logic              wr_ready,
    output logic              wr_refused,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ROW_W-1:0]  fl_row,
    input  logic              fl_gnt,
    input  logic              fl_rsp_valid,
    input  logic [STAT_W-1:0] fl_status,
    output logic              bad_valid,
    output logic [BLK_W-1:0]  bad_block,
    output logic              done_valid,
    output logic [BLK_W-1:0]  done_block
);

    wr_state_e         state_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PAGE_W-1:0] pg_q;
    logic              top_q;
    logic              acc;
    logic              try_top;
    stat_eval_t        st_res;
    flash_op_e         op_cur;

    nsw_page_tracker #(
        .PAGES   (PAGES),
        .NOP_MAX (NOP_MAX)
    ) u_trk (
        .clk       (clk),
        .rst       (rst),
        .load      ((state_q == ST_NEED_BLK) && tgt_valid),
        .try_valid ((state_q == ST_ACCEPT) && wr_valid),
        .try_page  (wr_page),
        .accept    (acc),
        .try_last  (try_top)
    );

    nsw_status_eval #(
        .STAT_W (STAT_W)
    ) u_st (
        .status   (fl_status),
        .top_page (top_q),
        .result   (st_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_NEED_BLK;
            blk_q      <= '0;
            pg_q       <= '0;
            top_q      <= 1'b0;
            wr_refused <= 1'b0;
            bad_valid  <= 1'b0;
            bad_block  <= '0;
            done_valid <= 1'b0;
            done_block <= '0;
        end else begin
            wr_refused <= 1'b0;
            bad_valid  <= 1'b0;
            done_valid <= 1'b0;
            unique case (state_q)
                ST_NEED_BLK: begin
                    if (tgt_valid) begin
                        blk_q   <= tgt_block;
                        state_q <= ST_ACCEPT;
                    end
                end
                ST_ACCEPT: begin
                    if (wr_valid) begin
                        if (acc) begin
                            pg_q    <= wr_page;
                            top_q   <= try_top;
                            state_q <= ST_PROG;
                        end else begin
                            wr_refused <= 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (fl_gnt) state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (fl_gnt) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fl_rsp_valid) begin
                        if (!st_res.ready) begin
                            state_q <= ST_POLL;
                        end else if (st_res.fail) begin
                            bad_valid <= 1'b1;
                            bad_block <= blk_q;
                            state_q   <= ST_NEED_BLK;
                        end else if (top_q) begin
                            done_valid <= 1'b1;
                            done_block <= blk_q;
                            state_q    <= ST_NEED_BLK;
                        end else begin
                            state_q <= ST_ACCEPT;
                        end
                    end
                end
                default: state_q <= ST_NEED_BLK;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PROG: op_cur = confirm_for(top_q);
            ST_POLL: op_cur = OP_STATUS;
            default: op_cur = OP_NONE;
        endcase
        wr_ready = (state_q == ST_ACCEPT);
        fl_req   = (state_q == ST_PROG) || (state_q == ST_POLL);
        fl_op    = op_cur;
        fl_row   = {blk_q, pg_q};
    end

endmodule

// File: rtl/nsw_checker.sv
module nsw_checker #(
    parameter  int PAGES  = 64,
    parameter  int BLOCKS = 2048,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int ROW_W  = BLK_W + PAGE_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             wr_refused,
    input logic             fl_req,
    input logic [1:0]       fl_op,
    input logic [ROW_W-1:0] fl_row,
    input logic             fl_gnt,
    input logic             bad_valid,
    input logic             done_valid
);

    localparam logic [PAGE_W-1:0] TOP_PAGE = PAGE_W'(PAGES - 1);

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_gnt) |=> (fl_req && $stable(fl_op) && $stable(fl_row)));

    // R4
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_refused |-> (!fl_req && wr_ready));

    // R3
    accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (wr_refused || (fl_req && (fl_op == 2'd1 || fl_op == 2'd2))));

    // R6
    cache_below_top_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_op == 2'd1) |-> (fl_row[PAGE_W-1:0] != TOP_PAGE));

    // R6
    last_on_top_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_op == 2'd2) |-> (fl_row[PAGE_W-1:0] == TOP_PAGE));

    // R7
    status_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_gnt && (fl_op == 2'd1 || fl_op == 2'd2)) |=> (fl_req && fl_op == 2'd3));

    // R8
    bad_stall_chk: assert property (@(posedge clk) disable iff (rst)
        bad_valid |-> (!wr_ready && !fl_req));

    // R9
    done_stall_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (!wr_ready && !fl_req && !bad_valid));

endmodule

bind nand_seq_writer nsw_checker #(
    .PAGES  (PAGES),
    .BLOCKS (BLOCKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_refused (wr_refused),
    .fl_req     (fl_req),
    .fl_op      (fl_op),
    .fl_row     (fl_row),
    .fl_gnt     (fl_gnt),
    .bad_valid  (bad_valid),
    .done_valid (done_valid)
);

// File: tb/nand_seq_writer_test.sv
`timescale 1ns/1ps
module nand_seq_writer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tgt_valid;
    logic [10:0] tgt_block;
    logic        wr_valid;
    logic [5:0]  wr_page;
    logic        wr_ready;
    logic        wr_refused;
    logic        fl_req;
    logic [1:0]  fl_op;
    logic [16:0] fl_row;
    logic        fl_gnt;
    logic        fl_rsp_valid;
    logic [7:0]  fl_status;
    logic        bad_valid;
    logic [10:0] bad_block;
    logic        done_valid;
    logic [10:0] done_block;

    always #2.5 clk = ~clk;

    nand_seq_writer uut (
        .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_block(tgt_block),
        .wr_valid(wr_valid), .wr_page(wr_page), .wr_ready(wr_ready), .wr_refused(wr_refused),
        .fl_req(fl_req), .fl_op(fl_op), .fl_row(fl_row), .fl_gnt(fl_gnt),
        .fl_rsp_valid(fl_rsp_valid), .fl_status(fl_status),
        .bad_valid(bad_valid), .bad_block(bad_block),
        .done_valid(done_valid), .done_block(done_block)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model: phases 0 wait block, 1 accept, 2 program, 3 poll, 4 wait status
    int m_ph, m_blk, m_pg, m_nxt, m_nop, m_bnum, m_dnum;
    bit m_ref, m_bad, m_done;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_blk = 0; m_pg = 0; m_nxt = 0; m_nop = 0;
            m_ref = 0; m_bad = 0; m_done = 0;
        end else begin
            m_ref = 0; m_bad = 0; m_done = 0;
            case (m_ph)
                0: if (tgt_valid) begin
                    m_blk = int'(tgt_block); m_nxt = 0; m_nop = 0; m_ph = 1;
                end
                1: if (wr_valid) begin
                    if (int'(wr_page) == m_nxt) begin
                        m_pg = int'(wr_page); m_nxt = (m_pg + 1) % 64; m_nop = 1; m_ph = 2;
                    end else if (m_nop > 0 && m_nop < 4 && int'(wr_page) == (m_nxt + 63) % 64) begin
                        m_pg = int'(wr_page); m_nop++; m_ph = 2;
                    end else begin
                        m_ref = 1;
                    end
                end
                2: if (fl_gnt) m_ph = 3;
                3: if (fl_gnt) m_ph = 4;
                4: if (fl_rsp_valid) begin
                    bit rdy;
                    rdy = (m_pg == 63) ? fl_status[5] : fl_status[6];
                    if (!rdy) m_ph = 3;
                    else if (fl_status[0]) begin m_bad = 1; m_bnum = m_blk; m_ph = 0; end
                    else if (m_pg == 63) begin m_done = 1; m_dnum = m_blk; m_ph = 0; end
                    else m_ph = 1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Flash responder settings and observation counters
    int  gdelay = 0, bpolls = 0, gcnt = 0, polls_left = 0;
    bit  fail_next = 0, rsp_pend = 0, rsp_top = 0;
    int  seen_ref = 0, seen_bad = 0, seen_done = 0, last_bad = -1, last_done = -1;
    int  stat_gnts = 0, prog_cyc = 0, last_prog_blk = -1, last_prog_op = -1;

    always @(negedge clk) begin
        if (rst) begin
            fl_gnt = 0; fl_rsp_valid = 0; fl_status = 8'h00; rsp_pend = 0; gcnt = 0;
        end else begin
            int exp_op;
            exp_op = (m_ph == 2) ? ((m_pg == 63) ? 2 : 1) : (m_ph == 3) ? 3 : 0;
            chk(wr_ready == (m_ph == 1), "R3 wr_ready", wr_ready, m_ph == 1);
            chk(wr_refused == m_ref, "R4 wr_refused", wr_refused, m_ref);
            chk(fl_req == (m_ph == 2 || m_ph == 3), "R7 fl_req", fl_req, m_ph == 2 || m_ph == 3);
            chk(int'(fl_op) == exp_op, "R6 fl_op", fl_op, exp_op);
            if (m_ph == 2 || m_ph == 3)
                chk(int'(fl_row) == m_blk * 64 + m_pg, "R6 fl_row", fl_row, m_blk * 64 + m_pg);
            chk(bad_valid == m_bad, "R8 bad_valid", bad_valid, m_bad);
            if (m_bad) chk(int'(bad_block) == m_bnum, "R8 bad_block", bad_block, m_bnum);
            chk(done_valid == m_done, "R9 done_valid", done_valid, m_done);
            if (m_done) chk(int'(done_block) == m_dnum, "R9 done_block", done_block, m_dnum);

            if (wr_refused) seen_ref++;
            if (bad_valid) begin seen_bad++; last_bad = int'(bad_block); end
            if (done_valid) begin seen_done++; last_done = int'(done_block); end
            if (fl_req && (fl_op == 2'd1 || fl_op == 2'd2)) begin
                prog_cyc++; last_prog_blk = int'(fl_row[16:6]); last_prog_op = int'(fl_op);
            end

            // Status response one cycle after a status grant
            if (rsp_pend) begin
                fl_rsp_valid = 1;
                if (polls_left > 0) begin
                    fl_status = rsp_top ? 8'h40 : 8'h20;
                    polls_left--;
                end else begin
                    fl_status = 8'h60 | {7'd0, fail_next};
                end
                rsp_pend = 0;
            end else begin
                fl_rsp_valid = 0;
            end
            // Grant after a programmable delay
            if (fl_req) begin
                if (gcnt >= gdelay) begin
                    fl_gnt = 1; gcnt = 0;
                    if (fl_op == 2'd3) begin
                        rsp_pend = 1; rsp_top = (fl_row[5:0] == 6'd63); stat_gnts++;
                    end else begin
                        polls_left = bpolls;
                    end
                end else begin
                    fl_gnt = 0; gcnt++;
                end
            end else begin
                fl_gnt = 0; gcnt = 0;
            end
        end
    end

    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            nfail++;
            $display("FAIL watchdog R3: actual %0d cycles expected completion", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic load_blk(input int b);
        @(negedge clk);
        tgt_valid = 1; tgt_block = 11'(b);
        @(negedge clk);
        tgt_valid = 0;
    endtask

    task automatic wr(input int p, input int gd, input int polls, input bit fail);
        gdelay = gd; bpolls = polls; fail_next = fail;
        for (int i = 0; i < 100 && !wr_ready; i++) @(negedge clk);
        wr_valid = 1; wr_page = 6'(p);
        @(negedge clk);
        wr_valid = 0;
        for (int i = 0; i < 200 && !(m_ph == 1 || m_ph == 0); i++) @(negedge clk);
    endtask

    initial begin
        rst = 1; tgt_valid = 0; tgt_block = '0; wr_valid = 0; wr_page = '0;
        fl_gnt = 0; fl_rsp_valid = 0; fl_status = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!wr_ready && !fl_req && !wr_refused && !bad_valid && !done_valid, "R1 reset outputs",
            {wr_ready, fl_req, wr_refused, bad_valid, done_valid}, 0);
        rst = 0;
        @(negedge clk);
        chk(!wr_ready && !fl_req, "R1 no block after reset", {wr_ready, fl_req}, 0);

        // Requests with no block are not taken
        wr_valid = 1; wr_page = 6'd0;
        repeat (2) @(negedge clk);
        wr_valid = 0;
        chk(seen_ref == 0 && !fl_req, "R2 request before block", seen_ref, 0);

        load_blk(5);
        wr(0, 0, 0, 0);
        wr(1, 2, 1, 0);
        stat_gnts = 0;
        wr(2, 0, 2, 0);
        chk(stat_gnts == 3, "R7 status polls for page 2", stat_gnts, 3);
        prog_cyc = 0;
        wr(3, 3, 0, 0);
        chk(prog_cyc == 4, "R11 program held until grant", prog_cyc, 4);

        wr(7, 0, 0, 0);
        wr(1, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(seen_ref == 2, "R4 out-of-order refusals", seen_ref, 2);

        wr(3, 0, 0, 0);
        wr(3, 1, 1, 0);
        wr(3, 0, 0, 0);
        wr(3, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(seen_ref == 3, "R5 partial program limit", seen_ref, 3);

        load_blk(11);
        wr(4, 0, 0, 0);
        chk(last_prog_blk == 5, "R2 block offer ignored while writing", last_prog_blk, 5);
        chk(wr_ready == 1, "R10 ready after cache pass", wr_ready, 1);

        for (int p = 5; p < 63; p++) wr(p, p % 3, p % 2, 0);
        wr(63, 1, 2, 0);
        repeat (2) @(negedge clk);
        chk(last_prog_op == 2, "R6 top page uses normal confirm", last_prog_op, 2);
        chk(seen_done == 1 && last_done == 5, "R9 block completion", last_done, 5);
        chk(!wr_ready, "R9 waits for block after completion", wr_ready, 0);

        load_blk(9);
        wr(0, 0, 0, 0);
        @(negedge clk);
        tgt_valid = 1; tgt_block = 11'd77;
        wr(1, 0, 1, 1);
        repeat (2) @(negedge clk);
        tgt_valid = 0;
        chk(seen_bad == 1 && last_bad == 9, "R8 failing program", last_bad, 9);
        wr(0, 0, 0, 0);
        chk(last_prog_blk == 77, "R8 restart in replacement block", last_prog_blk, 77);

        load_blk(30);
        for (int p = 1; p < 63; p++) wr(p, 0, 0, 0);
        wr(63, 0, 1, 1);
        repeat (2) @(negedge clk);
        chk(seen_bad == 2 && last_bad == 77, "R8 top page failure", last_bad, 77);
        chk(seen_done == 1, "R9 no completion on failure", seen_done, 1);

        load_blk(30);
        wr(0, 0, 0, 0);
        chk(last_prog_blk == 30, "R2 block loaded while waiting", last_prog_blk, 30);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule